// File: doc/BRIEF.md
# ADC Scan Sequence Controller

This block decides when an analog-to-digital converter steps through a scan of its enabled input channels. Software programs the scan through a register-style control port: channel mask, scan direction, sample time, single or continuous operation, trigger edge and trigger source, DMA enable and interrupt enables. It then sets the start bit. The start bit also acts as the busy indicator. Hardware clears it after a single software-started scan, or after a stop request. It stays set in continuous mode and in hardware-triggered single mode, so the next trigger edge launches a scan with no software involvement.

For each channel the controller pulses the converter core with a channel index and waits for the done strobe. It then writes the 12-bit result right-aligned into a 16-bit data register, sets the end-of-conversion flag and can raise a DMA request. After the last channel it also sets the end-of-sequence flag. The converter core is modelled by a stub whose latency is the programmed sample time plus 13 clocks, which is 12.5 converter clocks rounded up.

Top module: `adc_seq_ctrl`

## Requirements
- R1: In single mode (cont=0) with software trigger (edge field 2'b00), a start pulse converts every channel whose mask bit is set exactly once, lowest index first when the direction bit is 0. The start bit reads 0 in the cycle the last result appears, and no further conversion follows.
- R2: If start (software mode) or the qualifying trigger edge is driven in cycle t, the first result is visible in cycle t+smp+16. Each following result within a scan, including the first result of a continuous relaunch, appears smp+14 cycles after the previous one.
- R3: Each result appears on data_o as {4'b0, 12-bit sample of that channel} in the same cycle that eoc_o sets. Writing 1 to flag_clr_i bit 0 clears eoc_o on the next edge. All outputs are 0 after reset.
- R4: eos_o sets together with the eoc_o of the last channel of a scan and at no other conversion. Writing 1 to flag_clr_i bit 1 clears it.
- R5: irq_o is high exactly when (eoc_o and the end-of-conversion interrupt enable) or (eos_o and the end-of-sequence interrupt enable).
- R6: With the direction bit set to 1, the scan runs from the highest enabled channel down to the lowest.
- R7: Edge field 2'b01 launches on a rising edge, and 2'b10 on a falling edge, of trig_i[cfg_tsel_i]. Other trigger bits and the opposite edge have no effect. The start bit stays 1 after the scan.
- R8: A trigger edge that arrives while a scan is running does not start another scan.
- R9: In continuous mode (cont=1) the scan relaunches right after its last channel and the start bit stays 1.
- R10: A stop pulse makes the start bit read 0 in the next cycle. It abandons any conversion in flight, and no further result appears.
- R11: Configuration writes (cfg_we_i) are ignored while the start bit is 1.
- R12: With DMA enabled, dma_req_o pulses for exactly one cycle with each result. With DMA disabled it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_set_i | input | 1 | Pulse: write 1 to the start bit |
| stop_req_i | input | 1 | Pulse: stop request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_cont_i | input | 1 | Continuous mode |
| cfg_edge_i | input | 2 | Trigger edge: 00 software, 01 rising, 10 falling, 11 both |
| cfg_tsel_i | input | 2 | Trigger source index into trig_i |
| cfg_down_i | input | 1 | Scan direction, 1 = downward |
| cfg_chen_i | input | NCH | Channel enable mask |
| cfg_smp_i | input | SMP_W | Sample time in clocks |
| cfg_dma_en_i | input | 1 | DMA request enable |
| cfg_eoc_ie_i | input | 1 | End-of-conversion interrupt enable |
| cfg_eos_ie_i | input | 1 | End-of-sequence interrupt enable |
| flag_clr_i | input | 2 | Write-1-to-clear: bit 0 eoc, bit 1 eos |
| trig_i | input | NTRIG | Hardware trigger lines |
| samples_i | input | NCH*12 | Analog stand-in: 12-bit value per channel |
| start_o | output | 1 | Start / busy bit |
| data_o | output | 16 | Data register |
| eoc_o | output | 1 | End-of-conversion flag |
| eos_o | output | 1 | End-of-sequence flag |
| irq_o | output | 1 | Interrupt |
| dma_req_o | output | 1 | DMA request pulse |

## Verification
Every result is due at a cycle fixed by the sample time. The first result comes smp+16 cycles after the start or trigger cycle, and each later one follows smp+14 cycles after the one before. The bench works out each of these arrival cycles and compares it with the cycle in which eoc_o is first seen high, sampling on the falling clock edge. Start-bit clearing is checked in the same cycle as the last result. The stop response is checked exactly one cycle after the stop pulse. Cases that should produce nothing (ignored triggers, locked configuration, a finished or stopped scan) are watched for a fixed window of at least 30 cycles, longer than one conversion at the programmed sample time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned RES_W          = 12;
  localparam int unsigned DATA_W         = 16;
  // 12.5 converter clocks of fixed conversion overhead, rounded up
  localparam int unsigned CONV_FIXED_CYC = 13;

  typedef enum logic [1:0] {
    TRG_SW   = 2'b00,
    TRG_RISE = 2'b01,
    TRG_FALL = 2'b10,
    TRG_BOTH = 2'b11
  } trg_edge_e;
endpackage

// File: rtl/adc_trig_det.sv
module adc_trig_det
  import adc_seq_pkg::*;
#(
  parameter int unsigned NTRIG = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTRIG-1:0] trig_i,
  input  logic [SEL_W-1:0] sel_i,
  input  trg_edge_e        mode_i,
  output logic             hit_o
);
  logic smp_q, dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= 1'b0;
      dly_q <= 1'b0;
    end else begin
      smp_q <= trig_i[sel_i];
      dly_q <= smp_q;
    end
  end

  always_comb begin
    unique case (mode_i)
      TRG_RISE: hit_o = smp_q & ~dly_q;
      TRG_FALL: hit_o = ~smp_q & dly_q;
      TRG_BOTH: hit_o = smp_q ^ dly_q;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic [NCH-1:0]  en_i,
  input  logic [CH_W-1:0] cur_i,
  input  logic            down_i,
  output logic [CH_W-1:0] first_o,
  output logic [CH_W-1:0] next_o,
  output logic            last_o
);
  // Loop direction chosen so the final match is the nearest channel
  always_comb begin
    first_o = '0;
    next_o  = '0;
    last_o  = 1'b1;
    if (!down_i) begin
      for (int i = NCH - 1; i >= 0; i--) begin
        if (en_i[i]) first_o = CH_W'(i);
        if (en_i[i] && (CH_W'(i) > cur_i)) begin
          next_o = CH_W'(i);
          last_o = 1'b0;
        end
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (en_i[i]) first_o = CH_W'(i);
        if (en_i[i] && (CH_W'(i) < cur_i)) begin
          next_o = CH_W'(i);
          last_o = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_core_stub.sv
module adc_core_stub
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CH_W  = 3,
  parameter int unsigned SMP_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic [CH_W-1:0]    chan_i,
  input  logic [SMP_W-1:0]   smp_i,
  input  logic [NCH*RES_W-1:0] samples_i,
  output logic               done_o,
  output logic [RES_W-1:0]   result_o
);
  localparam int unsigned CNT_W = SMP_W + 4;

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] res_q;

  // done_o rises smp + CONV_FIXED_CYC cycles after the start pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(smp_i) + CNT_W'(CONV_FIXED_CYC - 2);
        res_q  <= samples_i[chan_i*RES_W +: RES_W];
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned NTRIG  = 4,
  parameter int unsigned SMP_W  = 4,
  localparam int unsigned CH_W   = $clog2(NCH),
  localparam int unsigned TSEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_set_i,
  input  logic                   stop_req_i,
  input  logic                   cfg_we_i,
  input  logic                   cfg_cont_i,
  input  logic [1:0]             cfg_edge_i,
  input  logic [TSEL_W-1:0]      cfg_tsel_i,
  input  logic                   cfg_down_i,
  input  logic [NCH-1:0]         cfg_chen_i,
  input  logic [SMP_W-1:0]       cfg_smp_i,
  input  logic                   cfg_dma_en_i,
  input  logic                   cfg_eoc_ie_i,
  input  logic                   cfg_eos_ie_i,
  input  logic [1:0]             flag_clr_i,
  input  logic [NTRIG-1:0]       trig_i,
  input  logic [NCH*RES_W-1:0]   samples_i,
  output logic                   start_o,
  output logic [DATA_W-1:0]      data_o,
  output logic                   eoc_o,
  output logic                   eos_o,
  output logic                   irq_o,
  output logic                   dma_req_o
);
  // configuration, writable only while idle
  logic              cont_q, down_q, dma_en_q, eoc_ie_q, eos_ie_q;
  trg_edge_e         trg_mode_q;
  logic [TSEL_W-1:0] tsel_q;
  logic [NCH-1:0]    chen_q;
  logic [SMP_W-1:0]  smp_q;

  logic              start_q, active_q, issue_q;
  logic [CH_W-1:0]   chan_q, first_ch, next_ch;
  logic              last_ch, trig_hit, launch, conv_done, core_done;
  logic [RES_W-1:0]  core_res;
  logic [DATA_W-1:0] data_q;
  logic              eoc_q, eos_q, dma_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_q     <= 1'b0;
      trg_mode_q <= TRG_SW;
      tsel_q     <= '0;
      down_q     <= 1'b0;
      chen_q     <= '0;
      smp_q      <= '0;
      dma_en_q   <= 1'b0;
      eoc_ie_q   <= 1'b0;
      eos_ie_q   <= 1'b0;
    end else if (cfg_we_i && !start_q) begin
      cont_q     <= cfg_cont_i;
      trg_mode_q <= trg_edge_e'(cfg_edge_i);
      tsel_q     <= cfg_tsel_i;
      down_q     <= cfg_down_i;
      chen_q     <= cfg_chen_i;
      smp_q      <= cfg_smp_i;
      dma_en_q   <= cfg_dma_en_i;
      eoc_ie_q   <= cfg_eoc_ie_i;
      eos_ie_q   <= cfg_eos_ie_i;
    end
  end

  adc_trig_det #(.NTRIG(NTRIG), .SEL_W(TSEL_W)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .sel_i  (tsel_q),
    .mode_i (trg_mode_q),
    .hit_o  (trig_hit)
  );

  adc_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
    .en_i    (chen_q),
    .cur_i   (chan_q),
    .down_i  (down_q),
    .first_o (first_ch),
    .next_o  (next_ch),
    .last_o  (last_ch)
  );

  adc_core_stub #(.NCH(NCH), .CH_W(CH_W), .SMP_W(SMP_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (issue_q),
    .abort_i   (stop_req_i),
    .chan_i    (chan_q),
    .smp_i     (smp_q),
    .samples_i (samples_i),
    .done_o    (core_done),
    .result_o  (core_res)
  );

  // triggers seen mid-scan fall through: launch needs an idle scanner
  assign launch    = start_q && !active_q && ((trg_mode_q == TRG_SW) || trig_hit);
  assign conv_done = active_q && core_done && !stop_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      active_q <= 1'b0;
      issue_q  <= 1'b0;
      chan_q   <= '0;
    end else if (stop_req_i) begin
      start_q  <= 1'b0;
      active_q <= 1'b0;
      issue_q  <= 1'b0;
    end else begin
      issue_q <= 1'b0;
      if (start_set_i && (|chen_q)) start_q <= 1'b1;
      if (launch) begin
        active_q <= 1'b1;
        chan_q   <= first_ch;
        issue_q  <= 1'b1;
      end else if (conv_done) begin
        if (!last_ch) begin
          chan_q  <= next_ch;
          issue_q <= 1'b1;
        end else if (cont_q) begin
          chan_q  <= first_ch;
          issue_q <= 1'b1;
        end else begin
          active_q <= 1'b0;
          if (trg_mode_q == TRG_SW) start_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      eoc_q  <= 1'b0;
      eos_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      dma_q <= conv_done && dma_en_q;
      if (conv_done) data_q <= DATA_W'(core_res);
      if (conv_done)          eoc_q <= 1'b1;
      else if (flag_clr_i[0]) eoc_q <= 1'b0;
      if (conv_done && last_ch) eos_q <= 1'b1;
      else if (flag_clr_i[1])   eos_q <= 1'b0;
    end
  end

  assign start_o   = start_q;
  assign data_o    = data_q;
  assign eoc_o     = eoc_q;
  assign eos_o     = eos_q;
  assign dma_req_o = dma_q;
  assign irq_o     = (eoc_q & eoc_ie_q) | (eos_q & eos_ie_q);
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int unsigned NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_o,
  input logic           eoc_o,
  input logic           eos_o,
  input logic           dma_req_o,
  input logic           stop_req_i,
  input logic           cfg_we_i,
  input logic           cont_q,
  input logic [1:0]     trg_mode_q,
  input logic [NCH-1:0] chen_q,
  input logic           issue_q,
  input logic           core_done
);
  p_sw_single_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(eos_o) && !cont_q && (trg_mode_q == 2'b00)) |-> !start_o);

  p_issue_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_q |=> !issue_q);

  p_done_apart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_done |-> !issue_q);

  p_eos_with_eoc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eos_o) |-> eoc_o);

  p_hw_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(eos_o) && (trg_mode_q != 2'b00)) |-> start_o);

  p_cont_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(eos_o) && cont_q) |-> start_o);

  p_stop_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_i |=> !start_o);

  p_cfg_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && cfg_we_i) |=> ($stable(chen_q) && $stable(cont_q) && $stable(trg_mode_q)));

  p_dma_with_eoc_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> eoc_o);

  p_dma_one_cycle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |=> !dma_req_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_o    (start_o),
  .eoc_o      (eoc_o),
  .eos_o      (eos_o),
  .dma_req_o  (dma_req_o),
  .stop_req_i (stop_req_i),
  .cfg_we_i   (cfg_we_i),
  .cont_q     (cont_q),
  .trg_mode_q (trg_mode_q),
  .chen_q     (chen_q),
  .issue_q    (issue_q),
  .core_done  (core_done)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_set_i = 1'b0, stop_req_i = 1'b0, cfg_we_i = 1'b0;
  logic        cfg_cont_i = 1'b0, cfg_down_i = 1'b0;
  logic [1:0]  cfg_edge_i = '0, cfg_tsel_i = '0, flag_clr_i = '0;
  logic [7:0]  cfg_chen_i = '0;
  logic [3:0]  cfg_smp_i = '0, trig_i = '0;
  logic        cfg_dma_en_i = 1'b0, cfg_eoc_ie_i = 1'b0, cfg_eos_ie_i = 1'b0;
  logic [95:0] samples_i;
  logic        start_o, eoc_o, eos_o, irq_o, dma_req_o;
  logic [15:0] data_o;

  int cyc = 0, n_vec = 0, n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  adc_seq_ctrl dut_i (.*);

  function automatic logic [15:0] exp_val(int ch);
    logic [11:0] v;
    v = 12'h0A5 + 12'h111 * 12'(ch);
    return {4'b0, v};
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic cfg(bit cont, logic [1:0] edg, logic [1:0] tsel, bit down, logic [7:0] chen,
                     int smp, bit dma, bit eie, bit sie);
    @(negedge clk_i);
    flag_clr_i = 2'b00;
    cfg_we_i = 1'b1; cfg_cont_i = cont; cfg_edge_i = edg; cfg_tsel_i = tsel;
    cfg_down_i = down; cfg_chen_i = chen; cfg_smp_i = 4'(smp);
    cfg_dma_en_i = dma; cfg_eoc_ie_i = eie; cfg_eos_ie_i = sie;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulse_start(output int t0);
    @(negedge clk_i);
    flag_clr_i = 2'b00;
    start_set_i = 1'b1; t0 = cyc;
    @(negedge clk_i);
    start_set_i = 1'b0;
  endtask

  task automatic drive_trig(logic [3:0] v, output int t0);
    @(negedge clk_i);
    flag_clr_i = 2'b00;
    trig_i = v; t0 = cyc;
  endtask

  task automatic pulse_stop(string rq);
    @(negedge clk_i);
    flag_clr_i = 2'b00;
    stop_req_i = 1'b1;
    @(negedge clk_i);
    stop_req_i = 1'b0;
    chk(start_o == 1'b0, rq, start_o, 0);
  endtask

  task automatic quiet(int n, bit exp_start, string rq);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      flag_clr_i = 2'b00;
      if (eoc_o) seen++;
    end
    chk(seen == 0, rq, seen, 0);
    chk(start_o == exp_start, rq, start_o, exp_start);
  endtask

  task automatic wait_eoc(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      flag_clr_i = 2'b00;
      if (eoc_o) begin
        at = cyc;
        break;
      end
    end
  endtask

  // Follows one whole scan; checks timing, order/data, dma, eos, irq, W1C
  task automatic expect_scan(logic [7:0] chen, bit down, int t0, int smp, bit dma,
                             bit eie, bit sie, bit keep, string rq, output int last_at);
    int exp_at = t0 + smp + 16;
    int total = $countones(chen);
    int n = 0;
    last_at = -1;
    for (int k = 0; k < 8; k++) begin
      int ch = down ? 7 - k : k;
      if (chen[ch]) begin
        int at;
        n++;
        wait_eoc(at);
        chk(at == exp_at, "R2 result cycle", at, exp_at);
        chk(data_o == exp_val(ch), {rq, " order/data R3"}, data_o, exp_val(ch));
        chk(dma_req_o == dma, "R12 dma", dma_req_o, dma);
        chk(eos_o == (n == total), "R4 eos", eos_o, n == total);
        chk(irq_o == (eie || (sie && n == total)), "R5 irq", irq_o, eie || (sie && n == total));
        if (n == total) chk(start_o == keep, "R1/R7/R9 start bit", start_o, keep);
        last_at = at;
        exp_at = at + smp + 14;
        flag_clr_i = 2'b11;
        @(negedge clk_i);
        flag_clr_i = 2'b00;
        chk(!eoc_o && !eos_o && !irq_o && !dma_req_o, "R3/R4 W1C", {eoc_o, eos_o, irq_o}, 0);
      end
    end
  endtask

  task automatic t_reset();
    chk(start_o == 0 && eoc_o == 0 && eos_o == 0, "R3 reset flags", {start_o, eoc_o, eos_o}, 0);
    chk(data_o == 0 && irq_o == 0 && dma_req_o == 0, "R3 reset data", data_o, 0);
  endtask

  task automatic t_single_up();
    int t0, la;
    cfg(0, 2'b00, 2'd0, 0, 8'b1010_0101, 2, 1, 0, 0);
    pulse_start(t0);
    expect_scan(8'b1010_0101, 0, t0, 2, 1, 0, 0, 0, "R1", la);
    quiet(40, 0, "R1 idle after scan");
  endtask

  task automatic t_down();
    int t0, la;
    cfg(0, 2'b00, 2'd0, 1, 8'b0110_0011, 0, 0, 0, 0);
    pulse_start(t0);
    expect_scan(8'b0110_0011, 1, t0, 0, 0, 0, 0, 0, "R6", la);
  endtask

  task automatic t_irq();
    int t0, la;
    cfg(0, 2'b00, 2'd0, 0, 8'b0000_0110, 1, 0, 1, 0);
    pulse_start(t0);
    expect_scan(8'b0000_0110, 0, t0, 1, 0, 1, 0, 0, "R5", la);
    cfg(0, 2'b00, 2'd0, 0, 8'b0001_0110, 3, 0, 0, 1);
    pulse_start(t0);
    expect_scan(8'b0001_0110, 0, t0, 3, 0, 0, 1, 0, "R5", la);
  endtask

  task automatic t_hw_rise();
    int t0, la;
    cfg(0, 2'b01, 2'd2, 0, 8'b0001_1000, 1, 1, 0, 0);
    pulse_start(t0);
    quiet(30, 1, "R7 waits for trigger");
    drive_trig(4'b0001, t0);
    quiet(30, 1, "R7 other trigger bit");
    drive_trig(4'b0000, t0);
    drive_trig(4'b0100, t0);
    expect_scan(8'b0001_1000, 0, t0, 1, 1, 0, 0, 1, "R7", la);
    drive_trig(4'b0000, t0);
    quiet(30, 1, "R7 falling edge ignored");
    drive_trig(4'b0100, t0);
    repeat (4) @(negedge clk_i);
    trig_i = 4'b0000;
    repeat (2) @(negedge clk_i);
    trig_i = 4'b0100;
    expect_scan(8'b0001_1000, 0, t0, 1, 1, 0, 0, 1, "R8", la);
    quiet(60, 1, "R8 mid-scan edge ignored");
    drive_trig(4'b0000, t0);
    pulse_stop("R10 stop while armed");
  endtask

  task automatic t_hw_fall_lock();
    int t0, la;
    cfg(0, 2'b10, 2'd2, 0, 8'b0001_1000, 2, 0, 0, 0);
    pulse_start(t0);
    drive_trig(4'b0100, t0);
    quiet(30, 1, "R7 rising ignored in falling mode");
    cfg(0, 2'b00, 2'd0, 1, 8'hFF, 0, 1, 1, 1);
    quiet(30, 1, "R11 locked cfg no launch");
    drive_trig(4'b0000, t0);
    expect_scan(8'b0001_1000, 0, t0, 2, 0, 0, 0, 1, "R11", la);
    pulse_stop("R10 stop after hw scan");
  endtask

  task automatic t_cont_stop();
    int t0, la;
    cfg(1, 2'b00, 2'd0, 0, 8'b1000_0001, 0, 1, 0, 0);
    pulse_start(t0);
    expect_scan(8'b1000_0001, 0, t0, 0, 1, 0, 0, 1, "R9", la);
    expect_scan(8'b1000_0001, 0, la - 2, 0, 1, 0, 0, 1, "R9 relaunch", la);
    repeat (5) @(negedge clk_i);
    pulse_stop("R10 stop in flight");
    quiet(60, 0, "R10 no result after stop");
  endtask

  initial begin
    for (int ch = 0; ch < 8; ch++) samples_i[ch*12 +: 12] = exp_val(ch)[11:0];
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single_up();
    t_down();
    t_irq();
    t_hw_rise();
    t_hw_fall_lock();
    t_cont_stop();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog R1-flow act=running exp=finished");
    summary();
  end
endmodule